// File: doc/BRIEF.md
# Multi-Mode DAC Code Sequencer

This block keeps a small table of 12-bit converter codes and a pointer into that table. The code under the pointer is driven onto a static output bus for the analog converter, and it stays there between triggers. Each trigger moves the pointer by one step. A trigger comes either from an external hardware pulse or from a software write. The step follows the selected pattern: a ring that wraps back to zero, a swing that climbs to the limit and descends again, or a single scan that parks at the limit. The limit is a programmable upper index.

Software reaches the table, the control fields and the status flags through a plain byte-wide register port. Writes take effect on the clock edge. Reads are combinational from the address. Hardware sets three flags: the pointer landed on zero, the pointer landed on the limit, or the pointer landed a programmable distance below the limit. Each enabled flag raises either an interrupt line or a DMA request line, depending on a steering bit. There is no streaming data path, so every pin is plain control or status and no handshake is involved.

Top module: `dac_ptr_seq`

## Requirements
- R1: Entry i sits at byte address 2i (code bits 7:0) and 2i+1 (code bits 11:8 in bits 3:0). Bits 7:4 of an odd address ignore writes and read as zero. All entries reset to zero.
- R2: With the enable bit clear (address 0x21 bit 0), `dac_code` shows entry 0 and no trigger moves the pointer.
- R3: With the enable bit set, `dac_code` shows the entry at the pointer and holds it unchanged while no trigger arrives.
- R4: Address 0x21 bit 1 selects the trigger source: 1 = software, 0 = hardware. In software mode, a write to 0x21 with bits 0, 1 and 2 all set makes one step, and bit 2 always reads 0. In hardware mode, each rising edge of `hw_trig` makes exactly one step after a two-flop synchroniser, whatever the pulse width, and the software bit has no effect.
- R5: Ring mode (address 0x22 bits 2:1 = 0, and also 3) steps 0,1,..,U and then goes to 0. A pointer above U steps to 0.
- R6: Swing mode (bits 2:1 = 1) steps 0,1,..,U,U-1,..,0,1,... With U = 0 the pointer stays at 0.
- R7: One-scan mode (bits 2:1 = 2) steps up to U and stays there on further triggers until the pointer is rewritten.
- R8: Address 0x23 holds the pointer in bits 3:0 and the limit U in bits 7:4. A write loads both and restarts a swing going upward.
- R9: Status at 0x20: bit 0 is set when a step lands on 0, and bit 1 is set when a step lands on U. Writing 0 to a bit clears it, and writing 1 leaves it unchanged. Pointer writes set no flag.
- R10: With w in 0x22 bits 4:3, status bit 2 is set when a step lands on index U-(w+1).
- R11: Address 0x21 bits 5:3 enable status bits 2:0. Any enabled flag that is set drives `irq` when 0x22 bit 0 is 0, and drives `dma_req` when it is 1. The two outputs are never high together.
- R12: After reset, 0x20, 0x21 and 0x22 read 0, 0x23 reads 0xF0, and `dac_code`, `irq` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_trig | input | 1 | Asynchronous hardware trigger, one step per rising edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| dac_code | output | 12 | Code driven to the converter |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The hardest behaviour to reach is the swing turn-around at every limit value. This includes the degenerate limit of zero and the step that follows a descent reaching index zero. Only a long run of triggers after a particular limit write gets there. The bench reaches it by sweeping every mode against all sixteen limits with software steps, enough steps to cover more than one full period. It compares the driven code after each step with a position computed arithmetically from the step count.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  localparam int unsigned NUM_ENTRIES = 16;
  localparam int unsigned CODE_W      = 12;
  localparam int unsigned PTR_W       = $clog2(NUM_ENTRIES);
  localparam int unsigned ADDR_W      = PTR_W + 2;
  localparam int unsigned NUM_FLAGS   = 3;

  typedef enum logic [1:0] {
    MODE_RING  = 2'd0,
    MODE_SWING = 2'd1,
    MODE_ONCE  = 2'd2,
    MODE_RSVD  = 2'd3
  } step_mode_e;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(2 * NUM_ENTRIES);
  localparam logic [ADDR_W-1:0] A_CTRL0  = ADDR_W'(2 * NUM_ENTRIES + 1);
  localparam logic [ADDR_W-1:0] A_CTRL1  = ADDR_W'(2 * NUM_ENTRIES + 2);
  localparam logic [ADDR_W-1:0] A_CTRL2  = ADDR_W'(2 * NUM_ENTRIES + 3);
endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pulse = sync_q[SYNC_STAGES-1] & ~last_q;

  // R4: a held level never yields two steps in a row
  a_r4_one_step_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/dac_code_store.sv
module dac_code_store
  import dac_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic              wr_hi,
  input  logic [7:0]        wr_byte,
  input  logic [PTR_W-1:0]  rd_idx,
  input  logic              rd_hi,
  output logic [7:0]        rd_byte,
  input  logic [PTR_W-1:0]  sel_idx,
  output logic [CODE_W-1:0] code
);
  localparam int unsigned HI_W = CODE_W - 8;

  logic [CODE_W-1:0] ent_q [NUM_ENTRIES];

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[gi] <= '0;
      end else if (wr_en && wr_idx == PTR_W'(gi)) begin
        if (wr_hi) ent_q[gi][CODE_W-1:8] <= wr_byte[HI_W-1:0];
        else       ent_q[gi][7:0]        <= wr_byte;
      end
    end
  end

  assign rd_byte = rd_hi ? {{(8-HI_W){1'b0}}, ent_q[rd_idx][CODE_W-1:8]}
                         : ent_q[rd_idx][7:0];
  assign code    = ent_q[sel_idx];
endmodule

// File: rtl/dac_ptr_step.sv
module dac_ptr_step
  import dac_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  step_mode_e           mode,
  input  logic [PTR_W-1:0]     upper,
  input  logic [1:0]           wm_sel,
  input  logic                 ptr_wr,
  input  logic [PTR_W-1:0]     ptr_wdata,
  input  logic                 dir_rst,
  input  logic                 clr_wr,
  input  logic [NUM_FLAGS-1:0] clr_keep,
  output logic [PTR_W-1:0]     ptr,
  output logic [NUM_FLAGS-1:0] flags
);
  logic               dir_up_q, dir_up_d;
  logic [PTR_W-1:0]   nxt;
  logic               moved;
  logic [PTR_W:0]     gap, wm_dist;
  logic [NUM_FLAGS-1:0] set_v;

  always_comb begin
    nxt      = ptr;
    dir_up_d = dir_up_q;
    moved    = 1'b0;
    if (step && !ptr_wr) begin
      unique case (mode)
        MODE_SWING: begin
          moved = 1'b1;
          if (dir_up_q) begin
            if (ptr >= upper) begin
              nxt      = (ptr == '0) ? '0 : ptr - 1'b1;
              dir_up_d = 1'b0;
            end else begin
              nxt = ptr + 1'b1;
            end
          end else begin
            if (ptr == '0) begin
              nxt      = (upper == '0) ? '0 : PTR_W'(1);
              dir_up_d = 1'b1;
            end else begin
              nxt = ptr - 1'b1;
            end
          end
        end
        MODE_ONCE: begin
          if (ptr < upper) begin
            nxt   = ptr + 1'b1;
            moved = 1'b1;
          end
        end
        default: begin
          moved = 1'b1;
          nxt   = (ptr >= upper) ? '0 : ptr + 1'b1;
        end
      endcase
    end
  end

  assign gap     = {1'b0, upper} - {1'b0, nxt};
  assign wm_dist = {{(PTR_W-1){1'b0}}, wm_sel} + 1'b1;

  assign set_v[0] = moved && (nxt == '0);
  assign set_v[1] = moved && (nxt == upper);
  assign set_v[2] = moved && (upper >= nxt) && (gap == wm_dist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      dir_up_q <= 1'b1;
      flags    <= '0;
    end else begin
      if (ptr_wr) ptr <= ptr_wdata;
      else        ptr <= nxt;
      dir_up_q <= (ptr_wr || dir_rst) ? 1'b1 : dir_up_d;
      flags    <= (clr_wr ? (flags & clr_keep) : flags) | set_v;
    end
  end

  // R5: ring mode returns to zero from the limit or above
  a_r5_ring_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ptr_wr && mode == MODE_RING && ptr >= upper) |=> ptr == '0);
  // R7: one-scan mode parks at the limit
  a_r7_once_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ptr_wr && mode == MODE_ONCE && ptr >= upper) |=> $stable(ptr));
  // R9: the top flag only rises with the pointer on the limit
  a_r9_top_flag_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> ptr == $past(upper));
endmodule

// File: rtl/dac_ptr_seq.sv
module dac_ptr_seq
  import dac_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_trig,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [CODE_W-1:0] dac_code,
  output logic              irq,
  output logic              dma_req
);
  logic                 buf_en_q, tsel_sw_q, dma_en_q;
  logic [NUM_FLAGS-1:0] ie_q;
  logic [1:0]           mode_q, wm_q;
  logic [PTR_W-1:0]     upper_q;
  logic                 hw_pulse, step, sw_hit;
  logic                 wr_ent, wr_st, wr_c0, wr_c1, wr_c2;
  logic [PTR_W-1:0]     ptr;
  logic [NUM_FLAGS-1:0] flags;
  logic [7:0]           ent_byte;
  logic                 req_any;

  assign wr_ent = reg_wr && (reg_addr < A_STATUS);
  assign wr_st  = reg_wr && (reg_addr == A_STATUS);
  assign wr_c0  = reg_wr && (reg_addr == A_CTRL0);
  assign wr_c1  = reg_wr && (reg_addr == A_CTRL1);
  assign wr_c2  = reg_wr && (reg_addr == A_CTRL2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_en_q  <= 1'b0;
      tsel_sw_q <= 1'b0;
      ie_q      <= '0;
      dma_en_q  <= 1'b0;
      mode_q    <= 2'd0;
      wm_q      <= 2'd0;
      upper_q   <= PTR_W'(NUM_ENTRIES - 1);
    end else begin
      if (wr_c0) begin
        buf_en_q  <= reg_wdata[0];
        tsel_sw_q <= reg_wdata[1];
        ie_q      <= reg_wdata[3 +: NUM_FLAGS];
      end
      if (wr_c1) begin
        dma_en_q <= reg_wdata[0];
        mode_q   <= reg_wdata[2:1];
        wm_q     <= reg_wdata[4:3];
      end
      if (wr_c2) upper_q <= reg_wdata[7:4];
    end
  end

  dac_trig_sync #(.SYNC_STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hw_trig), .pulse(hw_pulse)
  );

  assign sw_hit = wr_c0 && (reg_wdata[2:0] == 3'b111);
  assign step   = sw_hit || (buf_en_q && !tsel_sw_q && hw_pulse);

  dac_ptr_step i_step (
    .clk(clk), .rst_n(rst_n), .step(step), .mode(step_mode_e'(mode_q)),
    .upper(upper_q), .wm_sel(wm_q), .ptr_wr(wr_c2),
    .ptr_wdata(reg_wdata[PTR_W-1:0]), .dir_rst(wr_c1),
    .clr_wr(wr_st), .clr_keep(reg_wdata[NUM_FLAGS-1:0]),
    .ptr(ptr), .flags(flags)
  );

  dac_code_store i_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ent),
    .wr_idx(reg_addr[PTR_W:1]), .wr_hi(reg_addr[0]), .wr_byte(reg_wdata),
    .rd_idx(reg_addr[PTR_W:1]), .rd_hi(reg_addr[0]), .rd_byte(ent_byte),
    .sel_idx(buf_en_q ? ptr : '0), .code(dac_code)
  );

  always_comb begin
    if (reg_addr < A_STATUS)       reg_rdata = ent_byte;
    else if (reg_addr == A_STATUS) reg_rdata = {{(8-NUM_FLAGS){1'b0}}, flags};
    else if (reg_addr == A_CTRL0)  reg_rdata = {2'b00, ie_q, 1'b0, tsel_sw_q, buf_en_q};
    else if (reg_addr == A_CTRL1)  reg_rdata = {3'b000, wm_q, mode_q, dma_en_q};
    else if (reg_addr == A_CTRL2)  reg_rdata = {upper_q, ptr};
    else                           reg_rdata = 8'h00;
  end

  assign req_any = |(flags & ie_q);
  assign irq     = req_any && !dma_en_q;
  assign dma_req = req_any && dma_en_q;

  // R11: one request path at a time
  a_r11_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));
  // R2: a disabled buffer keeps its pointer unless software rewrites it
  a_r2_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en_q && !wr_c0 && !wr_c2) |=> $stable(ptr));
endmodule

// File: tb/test_dac_ptr_seq.sv
module test_dac_ptr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_trig = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [11:0] dac_code;
  logic irq, dma_req;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_ptr_seq i_dac_ptr_seq (
    .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dac_code(dac_code), .irq(irq), .dma_req(dma_req)
  );

  function automatic int code_of(int i);
    return (i * 397 + 11) % 4096;
  endfunction

  function automatic int exp_ptr(int mode, int u, int k);
    int p;
    if (mode == 2) return (k < u) ? k : u;
    if (mode == 1) begin
      if (u == 0) return 0;
      p = k % (2 * u);
      return (p <= u) ? p : 2 * u - p;
    end
    return k % (u + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic hw_pulse(int width);
    @(negedge clk);
    hw_trig = 1'b1;
    repeat (width) @(negedge clk);
    hw_trig = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int mode;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    rd(6'h20, d); chk("R12 status", d, 8'h00);
    rd(6'h21, d); chk("R12 ctrl0", d, 8'h00);
    rd(6'h22, d); chk("R12 ctrl1", d, 8'h00);
    rd(6'h23, d); chk("R12 ctrl2", d, 8'hF0);
    chk("R12 dac_code", dac_code, 0);
    chk("R12 irq", irq, 0);
    chk("R12 dma_req", dma_req, 0);
    rd(6'h07, d); chk("R1 reset entry", d, 0);

    // R1 table fill and readback; upper nibble of odd byte dropped
    for (int i = 0; i < 16; i++) begin
      wr(6'(2 * i), 8'(code_of(i) & 8'hFF));
      wr(6'(2 * i + 1), 8'hA0 | 8'(code_of(i) >> 8));
    end
    for (int i = 0; i < 16; i++) begin
      rd(6'(2 * i), d);     chk("R1 low byte", d, code_of(i) & 8'hFF);
      rd(6'(2 * i + 1), d); chk("R1 high byte", d, code_of(i) >> 8);
    end

    // R2 disabled: entry 0 shown, triggers ignored
    chk("R2 disabled code", dac_code, code_of(0));
    wr(6'h23, 8'hF5);
    chk("R2 disabled code after ptr write", dac_code, code_of(0));
    wr(6'h21, 8'h06);
    rd(6'h23, d); chk("R2 sw trigger ignored", d & 8'h0F, 5);
    wr(6'h21, 8'h02);

    // R5 R6 R7 R8: every mode against every limit
    for (int m = 0; m < 4; m++) begin
      mode = (m == 3) ? 0 : m;
      wr(6'h22, 8'(m << 1));
      for (int u = 0; u < 16; u++) begin
        wr(6'h23, 8'(u << 4));
        rd(6'h23, d); chk("R8 ctrl2 load", d, u << 4);
        for (int k = 1; k <= 2 * u + 3; k++) begin
          wr(6'h21, 8'h07);
          if (mode == 1)      chk("R6 swing code", dac_code, code_of(exp_ptr(mode, u, k)));
          else if (mode == 2) chk("R7 once code", dac_code, code_of(exp_ptr(mode, u, k)));
          else                chk("R5 ring code", dac_code, code_of(exp_ptr(mode, u, k)));
          rd(6'h23, d); chk("R3 pointer readback", d & 8'h0F, exp_ptr(mode, u, k));
        end
        if (mode == 2) begin
          wr(6'h23, 8'(u << 4));
          chk("R7 restart after rewrite", dac_code, code_of(0));
        end
      end
    end

    // R5 pointer above limit wraps
    wr(6'h22, 8'h00);
    wr(6'h23, 8'h39);
    wr(6'h21, 8'h07);
    chk("R5 above limit wraps", dac_code, code_of(0));

    // R3 hold between triggers
    wr(6'h21, 8'h07);
    repeat (10) @(negedge clk);
    chk("R3 hold", dac_code, code_of(1));

    // R4 hardware trigger: one step per edge, any width
    wr(6'h23, 8'hF0);
    wr(6'h21, 8'h01);
    hw_pulse(6);
    rd(6'h23, d); chk("R4 long pulse one step", d & 8'h0F, 1);
    hw_pulse(1);
    rd(6'h23, d); chk("R4 short pulse one step", d & 8'h0F, 2);
    wr(6'h21, 8'h05);
    rd(6'h23, d); chk("R4 sw ignored in hw mode", d & 8'h0F, 2);
    wr(6'h21, 8'h03);
    hw_pulse(3);
    rd(6'h23, d); chk("R4 hw ignored in sw mode", d & 8'h0F, 2);
    wr(6'h21, 8'h07);
    rd(6'h21, d); chk("R4 sw bit reads zero", d, 8'h03);

    // R9 flags and clearing
    wr(6'h22, 8'h00);
    wr(6'h23, 8'h30);
    wr(6'h20, 8'h00);
    rd(6'h20, d); chk("R9 cleared", d, 0);
    repeat (3) wr(6'h21, 8'h07);
    rd(6'h20, d); chk("R9 top and wm set", d, 8'h06);
    wr(6'h21, 8'h07);
    rd(6'h20, d); chk("R9 bottom set", d, 8'h07);
    wr(6'h20, 8'h05);
    rd(6'h20, d); chk("R9 selective clear", d, 8'h05);
    wr(6'h20, 8'h00);
    wr(6'h23, 8'h30);
    rd(6'h20, d); chk("R9 pointer write sets nothing", d, 0);

    // R10 watermark at distance 3 below limit 7
    wr(6'h22, 8'h10);
    wr(6'h23, 8'h70);
    repeat (3) wr(6'h21, 8'h07);
    rd(6'h20, d); chk("R10 not yet", d, 0);
    wr(6'h21, 8'h07);
    rd(6'h20, d); chk("R10 watermark", d, 8'h04);

    // R11 request steering
    wr(6'h22, 8'h00);
    wr(6'h23, 8'h70);
    wr(6'h20, 8'h00);
    wr(6'h21, 8'h13);
    chk("R11 idle irq", irq, 0);
    repeat (6) wr(6'h21, 8'h17);
    chk("R11 wm not enabled", irq, 0);
    wr(6'h21, 8'h17);
    chk("R11 irq on top", irq, 1);
    chk("R11 no dma", dma_req, 0);
    wr(6'h22, 8'h01);
    chk("R11 dma steered", dma_req, 1);
    chk("R11 irq off", irq, 0);
    wr(6'h20, 8'h00);
    chk("R11 dma cleared", dma_req, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule